// File: doc/BRIEF.md
# Secure Doorbell Mailbox

This block passes doorbell notifications between an application processor (the host) and a remote control processor. It holds two secure channels. The remote-to-host channel carries responses toward the host. The host-to-remote channel carries requests toward the remote side. Each channel keeps a 32-bit status word and has three registers: one to read the status, one that sets bits when a one is written to them, and one that clears bits when a one is written to them. A sender raises slot n by writing `1 << n` to the set register of its outgoing channel. The receiver sees an interrupt, reads the status, and releases the slot by writing the same bit to the clear register. A sender must not raise a slot again while that slot's bit is still set.

The two processors each reach the block through their own 32-bit register port. The request side is a valid/ready handshake. The read response is held in a one-entry output register with its own valid/ready pair, so a stalled response stalls new requests. Every request carries a secure attribute. A non-secure attempt on any channel register does not change the slots and reads back zero. Instead it sets bit 31 of the addressed channel's status, which flags the intrusion. For this reason only bits 30:0 carry messages.

Top module: `dbm_mailbox`

## Requirements
- R1: After reset both status words are zero, both interrupt outputs are low and neither port has a response pending.
- R2: A secure write to a set register ORs data bits 30:0 into that channel's status on the accepting clock edge and leaves all other bits unchanged. Data bit 31 of a set write has no effect.
- R3: A secure write to a clear register clears every status bit written as one and leaves the bits written as zero unchanged.
- R4: A secure read of a status register returns that channel's status as it was before the accepting edge. Reads of set, clear or unmapped offsets return zero, and writes to unmapped offsets change nothing.
- R5: A non-secure read or write to any of the six channel registers leaves bits 30:0 unchanged, reads back zero, and sets bit 31 of the addressed channel's status. A non-secure access to an unmapped offset has no effect.
- R6: Status bit 31 is cleared only by a secure write with bit 31 set to that channel's clear register.
- R7: When the two ports set and clear the same status bit on the same edge, the bit ends cleared. Other bits set in the same cycle are still raised.
- R8: Each interrupt output is the OR of all 32 bits of its channel status, delayed by one register. It changes one cycle after the status does.
- R9: A request is accepted on an edge where req_valid and req_ready are both high. req_ready is high when no response is pending or when rsp_ready is high. Each accepted request, read or write, yields exactly one response, and writes return zero data. A response whose rsp_ready is low stays valid with stable data.
- R10: Address map (12-bit byte offsets). The remote-to-host channel has status at 0x200, set at 0x208 and clear at 0x210, and drives irq_host. The host-to-remote channel has status at 0x300, set at 0x308 and clear at 0x310, and drives irq_remote. Both ports see the same map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Host request ready |
| host_req_write | input | 1 | Host request is a write |
| host_req_secure | input | 1 | Host request is secure |
| host_req_addr | input | 12 | Host byte offset |
| host_req_wdata | input | 32 | Host write data |
| host_rsp_valid | output | 1 | Host response valid |
| host_rsp_ready | input | 1 | Host accepts response |
| host_rsp_rdata | output | 32 | Host read data |
| rmt_req_valid | input | 1 | Remote request valid |
| rmt_req_ready | output | 1 | Remote request ready |
| rmt_req_write | input | 1 | Remote request is a write |
| rmt_req_secure | input | 1 | Remote request is secure |
| rmt_req_addr | input | 12 | Remote byte offset |
| rmt_req_wdata | input | 32 | Remote write data |
| rmt_rsp_valid | output | 1 | Remote response valid |
| rmt_rsp_ready | input | 1 | Remote accepts response |
| rmt_rsp_rdata | output | 32 | Remote read data |
| irq_host | output | 1 | Interrupt for the host, from the remote-to-host channel |
| irq_remote | output | 1 | Interrupt for the remote side, from the host-to-remote channel |

## Verification
The assertions check the following on every cycle:
- set and clear masks reach the status on the next edge, and a clear overrides a set;
- the status stays unchanged when no request touches it;
- the intrusion flag follows a non-secure hit;
- set masks never carry bit 31;
- the interrupts follow the status;
- a stalled response holds its data;
- a non-secure read returns zero.

Only the bench scenarios can show the rest:
- the address map itself, with each offset reaching the right channel and the right interrupt;
- that set, clear and unmapped offsets read zero;
- that two ports hitting the same bit on one edge end in a cleared bit;
- the whole flag sequence, from a non-secure attempt through the secure clear of bit 31.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int NCH = 2;
  localparam int NPORT = 2;
  localparam int CH_RH = 0;
  localparam int CH_HR = 1;
  localparam int FLAG_BIT = DW - 1;
  localparam logic [AW-1:0] RH_BASE = 12'h200;
  localparam logic [AW-1:0] HR_BASE = 12'h300;
  localparam logic [AW-1:0] OFF_STAT = 12'h000;
  localparam logic [AW-1:0] OFF_SET = 12'h008;
  localparam logic [AW-1:0] OFF_CLR = 12'h010;

  typedef logic [DW-1:0] word_t;

  localparam word_t FLAG_MASK = word_t'(1) << FLAG_BIT;
  localparam word_t SLOT_MASK = ~FLAG_MASK;

  function automatic logic [AW-1:0] ch_base(input int ch);
    return (ch == CH_RH) ? RH_BASE : HR_BASE;
  endfunction
endpackage

// File: rtl/dbm_port.sv
module dbm_port
  import dbm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic                     req_secure,
  input  logic [AW-1:0]            req_addr,
  input  word_t                    req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output word_t                    rsp_rdata,
  input  logic [NCH-1:0][DW-1:0]   stat,
  output logic [NCH-1:0][DW-1:0]   set_mask,
  output logic [NCH-1:0][DW-1:0]   clr_mask,
  output logic [NCH-1:0]           ns_hit
);
  logic accept;
  logic [NCH-1:0][DW-1:0] rd_part;
  word_t rd_word;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept = req_valid && req_ready;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    logic hit_stat, hit_set, hit_clr, sec_wr;
    assign hit_stat = (req_addr == ch_base(ch) + OFF_STAT);
    assign hit_set  = (req_addr == ch_base(ch) + OFF_SET);
    assign hit_clr  = (req_addr == ch_base(ch) + OFF_CLR);
    assign sec_wr   = accept && req_write && req_secure;
    assign set_mask[ch] = (sec_wr && hit_set) ? (req_wdata & SLOT_MASK) : '0;
    assign clr_mask[ch] = (sec_wr && hit_clr) ? req_wdata : '0;
    assign ns_hit[ch]   = accept && !req_secure && (hit_stat || hit_set || hit_clr);
    assign rd_part[ch]  = (hit_stat && req_secure) ? stat[ch] : '0;
  end

  always_comb begin
    rd_word = '0;
    for (int ch = 0; ch < NCH; ch++) rd_word = rd_word | rd_part[ch];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R5
  ns_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && !req_secure) |=> (rsp_rdata == '0));
endmodule

// File: rtl/dbm_chan.sv
module dbm_chan
  import dbm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORT-1:0][DW-1:0] set_in,
  input  logic [NPORT-1:0][DW-1:0] clr_in,
  input  logic [NPORT-1:0]         ns_in,
  output word_t                    stat,
  output logic                     irq
);
  word_t set_all, clr_all, nxt;
  logic flag;

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int p = 0; p < NPORT; p++) begin
      set_all = set_all | set_in[p];
      clr_all = clr_all | clr_in[p];
    end
    flag = |ns_in;
    nxt = (stat | set_all | (flag ? FLAG_MASK : '0)) & ~clr_all;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= nxt;
      irq  <= |stat;
    end
  end

  // R2
  set_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_all & ~clr_all) != '0) |=>
      ((stat & $past(set_all & ~clr_all)) == $past(set_all & ~clr_all)));

  // R3
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all != '0) |=> ((stat & $past(clr_all)) == '0));

  // R5
  flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_all[FLAG_BIT]) |=> stat[FLAG_BIT]);

  // R6
  no_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_all[FLAG_BIT]);

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all == '0 && clr_all == '0 && !flag) |=> $stable(stat));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|stat) |=> irq);

  // R8
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |=> !irq);
endmodule

// File: rtl/dbm_mailbox.sv
module dbm_mailbox
  import dbm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req_valid,
  output logic          host_req_ready,
  input  logic          host_req_write,
  input  logic          host_req_secure,
  input  logic [11:0]   host_req_addr,
  input  logic [31:0]   host_req_wdata,
  output logic          host_rsp_valid,
  input  logic          host_rsp_ready,
  output logic [31:0]   host_rsp_rdata,
  input  logic          rmt_req_valid,
  output logic          rmt_req_ready,
  input  logic          rmt_req_write,
  input  logic          rmt_req_secure,
  input  logic [11:0]   rmt_req_addr,
  input  logic [31:0]   rmt_req_wdata,
  output logic          rmt_rsp_valid,
  input  logic          rmt_rsp_ready,
  output logic [31:0]   rmt_rsp_rdata,
  output logic          irq_host,
  output logic          irq_remote
);
  logic [NPORT-1:0]           p_valid, p_ready, p_write, p_secure, p_rvalid, p_rready;
  logic [NPORT-1:0][AW-1:0]   p_addr;
  logic [NPORT-1:0][DW-1:0]   p_wdata, p_rdata;
  logic [NCH-1:0][DW-1:0]     stat;
  logic [NCH-1:0]             irq;
  logic [NPORT-1:0][NCH-1:0][DW-1:0] set_pc, clr_pc;
  logic [NPORT-1:0][NCH-1:0]  ns_pc;

  assign p_valid  = {rmt_req_valid, host_req_valid};
  assign p_write  = {rmt_req_write, host_req_write};
  assign p_secure = {rmt_req_secure, host_req_secure};
  assign p_rready = {rmt_rsp_ready, host_rsp_ready};
  assign p_addr   = {rmt_req_addr, host_req_addr};
  assign p_wdata  = {rmt_req_wdata, host_req_wdata};

  assign host_req_ready = p_ready[0];
  assign rmt_req_ready  = p_ready[1];
  assign host_rsp_valid = p_rvalid[0];
  assign rmt_rsp_valid  = p_rvalid[1];
  assign host_rsp_rdata = p_rdata[0];
  assign rmt_rsp_rdata  = p_rdata[1];
  assign irq_host   = irq[CH_RH];
  assign irq_remote = irq[CH_HR];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dbm_port u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (p_valid[p]),
      .req_ready (p_ready[p]),
      .req_write (p_write[p]),
      .req_secure(p_secure[p]),
      .req_addr  (p_addr[p]),
      .req_wdata (p_wdata[p]),
      .rsp_valid (p_rvalid[p]),
      .rsp_ready (p_rready[p]),
      .rsp_rdata (p_rdata[p]),
      .stat      (stat),
      .set_mask  (set_pc[p]),
      .clr_mask  (clr_pc[p]),
      .ns_hit    (ns_pc[p])
    );
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [NPORT-1:0][DW-1:0] set_in, clr_in;
    logic [NPORT-1:0]         ns_in;
    for (genvar p = 0; p < NPORT; p++) begin : g_x
      assign set_in[p] = set_pc[p][ch];
      assign clr_in[p] = clr_pc[p][ch];
      assign ns_in[p]  = ns_pc[p][ch];
    end
    dbm_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .set_in(set_in),
      .clr_in(clr_in),
      .ns_in (ns_in),
      .stat  (stat[ch]),
      .irq   (irq[ch])
    );
  end
endmodule

// File: tb/dbm_mailbox_test.sv
`timescale 1ns/1ps
module dbm_mailbox_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_v = 0, h_w = 0, h_s = 0, h_rr = 1;
  logic [11:0] h_a = '0;
  logic [31:0] h_d = '0;
  logic r_v = 0, r_w = 0, r_s = 0, r_rr = 1;
  logic [11:0] r_a = '0;
  logic [31:0] r_d = '0;
  logic h_rdy, h_rv, r_rdy, r_rv, irq_h, irq_r;
  logic [31:0] h_rd, r_rd;

  int n_chk = 0, n_fail = 0;
  logic [31:0] q0[$], q1[$];
  string t0[$], t1[$];
  bit done = 0;

  always #4 clk = ~clk;

  dbm_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(h_v), .host_req_ready(h_rdy), .host_req_write(h_w),
    .host_req_secure(h_s), .host_req_addr(h_a), .host_req_wdata(h_d),
    .host_rsp_valid(h_rv), .host_rsp_ready(h_rr), .host_rsp_rdata(h_rd),
    .rmt_req_valid(r_v), .rmt_req_ready(r_rdy), .rmt_req_write(r_w),
    .rmt_req_secure(r_s), .rmt_req_addr(r_a), .rmt_req_wdata(r_d),
    .rmt_rsp_valid(r_rv), .rmt_rsp_ready(r_rr), .rmt_rsp_rdata(r_rd),
    .irq_host(irq_h), .irq_remote(irq_r)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int p, input bit wr, input bit sec, input logic [11:0] a,
                     input logic [31:0] d, input logic [31:0] exp, input string tag);
    if (p == 0) begin
      h_v = 1; h_w = wr; h_s = sec; h_a = a; h_d = d;
      q0.push_back(exp); t0.push_back(tag);
    end else begin
      r_v = 1; r_w = wr; r_s = sec; r_a = a; r_d = d;
      q1.push_back(exp); t1.push_back(tag);
    end
  endtask

  task automatic fin();
    @(posedge clk);
    @(negedge clk);
    h_v = 0; r_v = 0;
  endtask

  task automatic bus(input int p, input bit wr, input bit sec, input logic [11:0] a,
                     input logic [31:0] d, input logic [31:0] exp, input string tag);
    put(p, wr, sec, a, d, exp, tag);
    fin();
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    if (rst_n && h_rv && h_rr) begin
      if (q0.size() == 0) chk("R9 host extra response", 32'h1, 32'h0);
      else chk(t0.pop_front(), h_rd, q0.pop_front());
    end
    if (rst_n && r_rv && r_rr) begin
      if (q1.size() == 0) chk("R9 remote extra response", 32'h1, 32'h0);
      else chk(t1.pop_front(), r_rd, q1.pop_front());
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #160000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_host", {31'b0, irq_h}, 0);
    chk("R1 irq_remote", {31'b0, irq_r}, 0);
    chk("R1 no response", {30'b0, h_rv, r_rv}, 0);
    bus(0, 0, 1, 12'h200, 0, 32'h0, "R1 rh status zero");
    bus(0, 0, 1, 12'h300, 0, 32'h0, "R1 hr status zero");

    // R2 R8 R10 set host-to-remote slot 5
    bus(0, 1, 1, 12'h308, 32'h20, 32'h0, "R9 write returns zero");
    chk("R8 irq_remote not yet", {31'b0, irq_r}, 0);
    @(negedge clk);
    chk("R8 irq_remote one cycle later", {31'b0, irq_r}, 1);
    chk("R10 irq_host untouched", {31'b0, irq_h}, 0);
    bus(0, 0, 1, 12'h300, 0, 32'h20, "R2 set slot 5");
    bus(0, 1, 1, 12'h308, 32'h8000_0003, 32'h0, "R2 set write");
    bus(1, 0, 1, 12'h300, 0, 32'h23, "R2 bit 31 of set ignored");

    // R4 read-zero offsets and unmapped write
    bus(0, 0, 1, 12'h308, 0, 32'h0, "R4 set offset reads zero");
    bus(0, 0, 1, 12'h310, 0, 32'h0, "R4 clear offset reads zero");
    bus(0, 1, 1, 12'h304, 32'hFFFF_FFFF, 32'h0, "R4 unmapped write");
    bus(0, 0, 1, 12'h300, 0, 32'h23, "R4 unmapped write no effect");
    bus(0, 0, 1, 12'h304, 0, 32'h0, "R4 unmapped read zero");

    // R10 remote-to-host channel
    bus(1, 1, 1, 12'h208, 32'h400, 32'h0, "R10 rmt set write");
    bus(0, 0, 1, 12'h200, 0, 32'h400, "R10 rh status");
    chk("R10 irq_host", {31'b0, irq_h}, 1);

    // R3 clear
    bus(1, 1, 1, 12'h310, 32'h21, 32'h0, "R3 clear write");
    bus(0, 0, 1, 12'h300, 0, 32'h2, "R3 partial clear");
    bus(1, 1, 1, 12'h310, 32'h2, 32'h0, "R3 clear write");
    bus(0, 0, 1, 12'h300, 0, 32'h0, "R3 full clear");
    chk("R8 irq_remote low", {31'b0, irq_r}, 0);

    // R5 non-secure accesses
    bus(0, 1, 0, 12'h308, 32'hFF, 32'h0, "R5 ns write returns zero");
    bus(0, 0, 1, 12'h300, 0, 32'h8000_0000, "R5 ns write flagged only");
    chk("R5 R8 flag raises irq_remote", {31'b0, irq_r}, 1);
    bus(1, 0, 0, 12'h200, 0, 32'h0, "R5 ns read zero");
    bus(1, 0, 1, 12'h200, 0, 32'h8000_0400, "R5 ns read flagged");
    bus(0, 1, 0, 12'h314, 32'hFF, 32'h0, "R5 ns unmapped write");
    bus(0, 0, 1, 12'h300, 0, 32'h8000_0000, "R5 ns unmapped no effect");

    // R6 flag clearing
    bus(0, 1, 1, 12'h210, 32'h0000_0400, 32'h0, "R6 clear slot only");
    bus(0, 0, 1, 12'h200, 0, 32'h8000_0000, "R6 flag survives slot clear");
    bus(0, 1, 1, 12'h210, 32'h8000_0000, 32'h0, "R6 clear flag");
    bus(0, 0, 1, 12'h200, 0, 32'h0, "R6 flag cleared");
    bus(1, 1, 1, 12'h310, 32'h8000_0000, 32'h0, "R6 clear hr flag");
    bus(1, 0, 1, 12'h300, 0, 32'h0, "R6 hr flag cleared");
    bus(0, 1, 1, 12'h308, 32'h8000_0000, 32'h0, "R6 set bit 31");
    bus(0, 0, 1, 12'h300, 0, 32'h0, "R6 set cannot raise flag");

    // R7 simultaneous set and clear from both ports
    put(0, 1, 1, 12'h308, 32'h1, 32'h0, "R7 host set");
    put(1, 1, 1, 12'h310, 32'h1, 32'h0, "R7 rmt clear");
    fin();
    bus(0, 0, 1, 12'h300, 0, 32'h0, "R7 clear wins");
    bus(0, 1, 1, 12'h308, 32'h10, 32'h0, "R7 pre-set");
    put(0, 1, 1, 12'h308, 32'h18, 32'h0, "R7 host set");
    put(1, 1, 1, 12'h310, 32'h10, 32'h0, "R7 rmt clear");
    fin();
    bus(1, 0, 1, 12'h300, 0, 32'h8, "R7 clear wins other bit set");
    @(negedge clk);
    chk("R8 irq_host low", {31'b0, irq_h}, 0);

    // R9 back-pressure
    h_rr = 0;
    bus(0, 0, 1, 12'h300, 0, 32'h8, "R9 stalled read");
    chk("R9 rsp valid held", {31'b0, h_rv}, 1);
    chk("R9 req_ready low", {31'b0, h_rdy}, 0);
    repeat (2) @(negedge clk);
    chk("R9 data stable", h_rd, 32'h8);
    chk("R9 still valid", {31'b0, h_rv}, 1);
    @(posedge clk);
    #2 h_rr = 1;
    repeat (2) @(negedge clk);
    chk("R9 response retired", {31'b0, h_rv}, 0);
    chk("R9 all responses seen", q0.size() + q1.size(), 0);
    done = 1;
    summary();
  end
endmodule